// File: doc/BRIEF.md
# Graphics Command Packet Parser

This block sits at the front of a rasteriser. It accepts a stream of 32-bit command words under a valid/ready handshake and cuts the stream into packets. The top byte of a packet's first word is the opcode, and a fixed per-opcode table gives the number of parameter words that follow. Drawing packets leave on a registered draw port with start-of-packet and end-of-packet markers. Image-transfer packets never reach that port. Their position and size words go to a separate transfer engine as a one-cycle request.

While packets pass through, the parser keeps state for the rest of the pipeline. It holds eight 32-bit environment registers, which single-word environment commands overwrite. It picks the texture-page field out of a fixed parameter word of textured primitives and writes it into environment register 1. It presents a 13-bit status field built from two of the environment registers. It also raises a sticky framebuffer-dirty flag, which the consumer clears.

Top module: `gfx_cmd_parser`

## Requirements
- R1: A packet is 1 + E words long. E is selected by the opcode in bits 31:24 of the first word:
  - E = 2 for 0x02.
  - 0x20-0x3F in blocks of four opcodes: 3, 6, 4, 8, 5, 8, 7, 11.
  - E = 2 for 0x40-0x47, 3 for 0x48-0x57, 4 for 0x58-0x5F.
  - 0x60-0x7F in blocks of four opcodes: 2, 3, 1, 0, 1, 2, 1, 2.
  - E = 3 for 0x80, and 2 for both 0xA0 and 0xC0.
  - E = 0 for every other opcode.
- R2: Each accepted word of a drawing packet appears on draw_data one cycle after acceptance, in order. draw_sop is set on the first word and draw_eop on the last.
- R3: An opcode whose top five bits are 11100 (0xE0-0xE7) stores its whole first word in environment register (opcode & 7). The register is visible on env_flat bits [32*n+31:32*n] one cycle later.
- R4: If (opcode & 0xF4) == 0x24, bits 8:0 of packet word 4 (counting from 0) replace bits 8:0 of environment register 1. If (opcode & 0xF4) == 0x34, packet word 5 is used instead. The other bits of the register are unchanged.
- R5: status_low[10:0] equals environment register 1 bits 10:0, and status_low[12:11] equals environment register 6 bits 1:0.
- R6: Opcodes 0xA0 and 0xC0 produce no draw output. One cycle after their third word is accepted, xfer_valid pulses for one cycle. At that point xfer_pos holds the second word, xfer_size holds the third word, and xfer_is_read is 1 for 0xC0 and 0 for 0xA0.
- R7: in_ready is low while xfer_valid or xfer_busy is high, and high otherwise.
- R8: The first word of any opcode from 0x02 up to 0xBF sets fb_dirty, visible one cycle later. Other opcodes leave it unchanged. dirty_clr clears the flag one cycle later; a set in the same cycle wins.
- R9: A partly received packet waits through idle cycles (in_valid low) and continues at the correct word position.
- R10: After reset:
  - draw_valid, xfer_valid, fb_dirty and status_low are 0.
  - in_ready is 1 while xfer_busy is low.
  - Environment register n holds (0xE0 + n) in bits 31:24 and zero below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Parser can accept a word |
| draw_valid | output | 1 | Draw word valid |
| draw_data | output | 32 | Forwarded packet word |
| draw_sop | output | 1 | First word of a packet |
| draw_eop | output | 1 | Last word of a packet |
| xfer_valid | output | 1 | One-cycle transfer request |
| xfer_is_read | output | 1 | 1 = read from image memory, 0 = write to it |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_busy | input | 1 | Transfer engine is busy |
| env_flat | output | 256 | Eight environment registers, register n at bits 32n+31:32n |
| status_low | output | 13 | Mirrored status bits |
| fb_dirty | output | 1 | Sticky framebuffer-dirty flag |
| dirty_clr | input | 1 | Clears fb_dirty |

## Verification
Every result is due exactly one clock edge after the edge that accepts the word causing it:
- a forwarded draw word;
- an environment or texture-page update and the status mirror that follows it;
- the dirty flag;
- the transfer request.

The bench drives one word per cycle and watches the outputs on the falling edge, so each word is seen in the cycle after its acceptance. Per-packet comparisons wait two falling edges after the last word, which covers that single register stage. in_ready is checked on the first two falling edges after a transfer's final word. On the first, the request pulse blocks intake; on the second, the engine model's busy signal does.

// File: rtl/gfxp_pkg.sv
package gfxp_pkg;

  localparam int OP_W  = 8;
  localparam int CNT_W = 4;

  // extra parameter words that follow the first word of a packet
  function automatic logic [CNT_W-1:0] extra_words(input logic [OP_W-1:0] op);
    logic [CNT_W-1:0] e;
    e = '0;
    case (op[7:5])
      3'b001: begin
        case (op[4:2])
          3'd0: e = 4'd3;
          3'd1: e = 4'd6;
          3'd2: e = 4'd4;
          3'd3: e = 4'd8;
          3'd4: e = 4'd5;
          3'd5: e = 4'd8;
          3'd6: e = 4'd7;
          default: e = 4'd11;
        endcase
      end
      3'b010: begin
        if (op[4:3] == 2'b00)      e = 4'd2;
        else if (op[4:3] == 2'b11) e = 4'd4;
        else                       e = 4'd3;
      end
      3'b011: begin
        case (op[4:2])
          3'd0: e = 4'd2;
          3'd1: e = 4'd3;
          3'd2: e = 4'd1;
          3'd3: e = 4'd0;
          3'd4: e = 4'd1;
          3'd5: e = 4'd2;
          3'd6: e = 4'd1;
          default: e = 4'd2;
        endcase
      end
      default: begin
        if (op == 8'h02)                     e = 4'd2;
        else if (op == 8'h80)                e = 4'd3;
        else if (op == 8'hA0 || op == 8'hC0) e = 4'd2;
        else                                 e = 4'd0;
      end
    endcase
    return e;
  endfunction

endpackage

// File: rtl/gfxp_len_decode.sv
module gfxp_len_decode
  import gfxp_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic [OP_W-1:0] op,
  output logic [CW-1:0]   total_len,
  output logic            is_xfer,
  output logic            is_read,
  output logic            dirty,
  output logic            snoop_ok,
  output logic [CW-1:0]   snoop_idx
);

  localparam logic [OP_W-1:0] XFER_WR   = 8'hA0;
  localparam logic [OP_W-1:0] XFER_RD   = 8'hC0;
  localparam logic [OP_W-1:0] TEX_MASK  = 8'hF4;
  localparam logic [OP_W-1:0] TEX_FLAT  = 8'h24;
  localparam logic [OP_W-1:0] TEX_SHADE = 8'h34;

  always_comb begin
    total_len = CW'(extra_words(op)) + CW'(1);
    is_xfer   = (op == XFER_WR) || (op == XFER_RD);
    is_read   = (op == XFER_RD);
    dirty     = (op >= 8'h02) && (op < XFER_RD);
    snoop_ok  = 1'b0;
    snoop_idx = '0;
    if ((op & TEX_MASK) == TEX_FLAT) begin
      snoop_ok  = 1'b1;
      snoop_idx = CW'(4);
    end else if ((op & TEX_MASK) == TEX_SHADE) begin
      snoop_ok  = 1'b1;
      snoop_idx = CW'(5);
    end
  end

endmodule

// File: rtl/gfxp_env_file.sv
module gfxp_env_file #(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int TP_W   = 9,
  parameter int STAT_W = 13
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [$clog2(NREG)-1:0] wr_sel,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   tp_en,
  input  logic [TP_W-1:0]        tp_data,
  output logic [NREG*DATA_W-1:0] env_flat,
  output logic [STAT_W-1:0]      status_low
);

  localparam int SEL_W  = $clog2(NREG);
  localparam int TP_REG = 1;
  localparam int MSK_REG = 6;
  localparam int TP_MIR_W = 11;
  localparam int MSK_MIR_W = STAT_W - TP_MIR_W;
  localparam logic [7:0] TAG_BASE = 8'hE0;

  logic [DATA_W-1:0] env_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        env_q[i] <= {TAG_BASE + 8'(i), {(DATA_W-8){1'b0}}};
      end else if (wr_en && wr_sel == SEL_W'(i)) begin
        env_q[i] <= wr_data;
      end else if (tp_en && i == TP_REG) begin
        env_q[i][TP_W-1:0] <= tp_data;
      end
    end
    assign env_flat[i*DATA_W +: DATA_W] = env_q[i];
  end

  assign status_low = {env_q[MSK_REG][MSK_MIR_W-1:0], env_q[TP_REG][TP_MIR_W-1:0]};

  AST_ENV_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> env_q[$past(wr_sel)] == $past(wr_data)); // R3

  AST_TEX_SNOOP: assert property (@(posedge clk) disable iff (rst)
    (tp_en && !wr_en) |=> env_q[TP_REG][TP_W-1:0] == $past(tp_data)); // R4

endmodule

// File: rtl/gfxp_xfer_latch.sv
module gfxp_xfer_latch #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pos_en,
  input  logic              fire,
  input  logic              rd_in,
  input  logic [DATA_W-1:0] data,
  output logic              req_valid,
  output logic              req_read,
  output logic [DATA_W-1:0] req_pos,
  output logic [DATA_W-1:0] req_size
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_read  <= 1'b0;
      req_pos   <= '0;
      req_size  <= '0;
    end else begin
      req_valid <= fire;
      if (pos_en) req_pos <= data;
      if (fire) begin
        req_size <= data;
        req_read <= rd_in;
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid); // R6

endmodule

// File: rtl/gfx_cmd_parser.sv
module gfx_cmd_parser
  import gfxp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int TP_W   = 9,
  parameter int STAT_W = 13
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [DATA_W-1:0]      in_data,
  output logic                   in_ready,
  output logic                   draw_valid,
  output logic [DATA_W-1:0]      draw_data,
  output logic                   draw_sop,
  output logic                   draw_eop,
  output logic                   xfer_valid,
  output logic                   xfer_is_read,
  output logic [DATA_W-1:0]      xfer_pos,
  output logic [DATA_W-1:0]      xfer_size,
  input  logic                   xfer_busy,
  output logic [NREG*DATA_W-1:0] env_flat,
  output logic [STAT_W-1:0]      status_low,
  output logic                   fb_dirty,
  input  logic                   dirty_clr
);

  localparam int SEL_W = $clog2(NREG);
  localparam int OP_LSB = DATA_W - OP_W;
  localparam logic [4:0] ENV_TAG = 5'b11100;

  logic [CNT_W-1:0] idx_q;
  logic [OP_W-1:0]  op_q;
  logic             acc, first, last;
  logic [OP_W-1:0]  cur_op;
  logic [CNT_W-1:0] dec_len, dec_sidx;
  logic             dec_xfer, dec_read, dec_dirty, dec_sok;
  logic             env_wr, tp_en;

  assign in_ready = ~xfer_busy & ~xfer_valid;
  assign acc      = in_valid & in_ready;
  assign first    = (idx_q == '0);
  assign cur_op   = first ? in_data[DATA_W-1:OP_LSB] : op_q;
  assign last     = (idx_q == dec_len - CNT_W'(1));

  gfxp_len_decode #(.CW(CNT_W)) u_dec (
    .op(cur_op), .total_len(dec_len), .is_xfer(dec_xfer), .is_read(dec_read),
    .dirty(dec_dirty), .snoop_ok(dec_sok), .snoop_idx(dec_sidx)
  );

  // packet position tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      op_q  <= '0;
    end else if (acc) begin
      if (first) op_q <= cur_op;
      idx_q <= last ? '0 : idx_q + CNT_W'(1);
    end
  end

  // draw port
  always_ff @(posedge clk) begin
    if (rst) begin
      draw_valid <= 1'b0;
      draw_data  <= '0;
      draw_sop   <= 1'b0;
      draw_eop   <= 1'b0;
    end else begin
      draw_valid <= acc & ~dec_xfer;
      if (acc & ~dec_xfer) begin
        draw_data <= in_data;
        draw_sop  <= first;
        draw_eop  <= last;
      end
    end
  end

  // dirty flag, set wins over clear
  always_ff @(posedge clk) begin
    if (rst)                         fb_dirty <= 1'b0;
    else if (acc & first & dec_dirty) fb_dirty <= 1'b1;
    else if (dirty_clr)              fb_dirty <= 1'b0;
  end

  assign env_wr = acc & first & (cur_op[OP_W-1:3] == ENV_TAG);
  assign tp_en  = acc & dec_sok & (idx_q == dec_sidx);

  gfxp_env_file #(.DATA_W(DATA_W), .NREG(NREG), .TP_W(TP_W), .STAT_W(STAT_W)) u_env (
    .clk(clk), .rst(rst), .wr_en(env_wr), .wr_sel(cur_op[SEL_W-1:0]), .wr_data(in_data),
    .tp_en(tp_en), .tp_data(in_data[TP_W-1:0]), .env_flat(env_flat), .status_low(status_low)
  );

  gfxp_xfer_latch #(.DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst(rst),
    .pos_en(acc & dec_xfer & (idx_q == CNT_W'(1))),
    .fire(acc & dec_xfer & (idx_q == CNT_W'(2))),
    .rd_in(dec_read), .data(in_data),
    .req_valid(xfer_valid), .req_read(xfer_is_read), .req_pos(xfer_pos), .req_size(xfer_size)
  );

  AST_STATUS_MASK: assert property (@(posedge clk) disable iff (rst)
    (acc && first && in_data[DATA_W-1:OP_LSB] == 8'hE6) |=> status_low[12:11] == $past(in_data[1:0])); // R5

  AST_XFER_NO_DRAW: assert property (@(posedge clk) disable iff (rst)
    xfer_valid |-> !draw_valid); // R6

  AST_DIRTY_SET: assert property (@(posedge clk) disable iff (rst)
    (acc && first && in_data[DATA_W-1:OP_LSB] >= 8'h02 && in_data[DATA_W-1:OP_LSB] < 8'hC0) |=> fb_dirty); // R8

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && xfer_busy && !first) |=> $stable(idx_q)); // R9

endmodule

// File: tb/gfx_cmd_parser_test.sv
`timescale 1ns/1ps
module gfx_cmd_parser_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready;
  logic draw_valid, draw_sop, draw_eop;
  logic [31:0] draw_data;
  logic xfer_valid, xfer_is_read;
  logic [31:0] xfer_pos, xfer_size;
  logic xfer_busy;
  logic [255:0] env_flat;
  logic [12:0] status_low;
  logic fb_dirty;
  logic dirty_clr = 1'b0;

  always #2 clk = ~clk;

  gfx_cmd_parser uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .draw_valid(draw_valid), .draw_data(draw_data), .draw_sop(draw_sop), .draw_eop(draw_eop),
    .xfer_valid(xfer_valid), .xfer_is_read(xfer_is_read), .xfer_pos(xfer_pos),
    .xfer_size(xfer_size), .xfer_busy(xfer_busy), .env_flat(env_flat),
    .status_low(status_low), .fb_dirty(fb_dirty), .dirty_clr(dirty_clr)
  );

  // transfer engine model: busy for five cycles after each request
  int busy_cnt;
  always @(posedge clk) begin
    if (rst) busy_cnt <= 0;
    else if (xfer_valid) busy_cnt <= 5;
    else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end
  assign xfer_busy = (busy_cnt != 0);

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // output logs, sampled on the falling edge
  int dcnt = 0;
  logic [31:0] dlog [16];
  logic dsop [16];
  logic deop [16];
  int xcnt = 0;
  logic [31:0] xp, xs;
  logic xr;

  always @(negedge clk) begin
    if (!rst && draw_valid && dcnt < 16) begin
      dlog[dcnt] = draw_data;
      dsop[dcnt] = draw_sop;
      deop[dcnt] = draw_eop;
      dcnt = dcnt + 1;
    end
    if (!rst && xfer_valid) begin
      xp = xfer_pos; xs = xfer_size; xr = xfer_is_read;
      xcnt = xcnt + 1;
    end
  end

  logic [31:0] em [8];

  task automatic chk(input logic ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int extra_of(input logic [7:0] op);
    int blk;
    blk = op / 4;
    if (op == 8'h02) return 2;
    if (op >= 8'h20 && op < 8'h40) begin
      case (blk - 8)
        0: return 3; 1: return 6; 2: return 4; 3: return 8;
        4: return 5; 5: return 8; 6: return 7; default: return 11;
      endcase
    end
    if (op >= 8'h40 && op < 8'h48) return 2;
    if (op >= 8'h48 && op < 8'h58) return 3;
    if (op >= 8'h58 && op < 8'h60) return 4;
    if (op >= 8'h60 && op < 8'h80) begin
      case (blk - 24)
        0: return 2; 1: return 3; 2: return 1; 3: return 0;
        4: return 1; 5: return 2; 6: return 1; default: return 2;
      endcase
    end
    if (op == 8'h80) return 3;
    if (op == 8'hA0 || op == 8'hC0) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] pw(input logic [7:0] op, input int k);
    if (k == 0) return {op, op ^ 8'h5A, 8'(op * 3), 8'(op + 7)};
    return {8'(k * 17 + op), op ^ 8'hC3, 8'(k), 8'(op * 5 + k)};
  endfunction

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  function automatic void model_pkt(input logic [7:0] op, input int n);
    if (op[7:3] == 5'b11100) em[op[2:0]] = pw(op, 0);
    if ((op & 8'hF4) == 8'h24) em[1][8:0] = pw(op, 4) & 32'h1FF;
    if ((op & 8'hF4) == 8'h34) em[1][8:0] = pw(op, 5) & 32'h1FF;
    if (n < 0) em[0] = em[0];
  endfunction

  task automatic check_state(input logic [7:0] op);
    logic [255:0] exp_env;
    for (int i = 0; i < 8; i++) exp_env[i*32 +: 32] = em[i];
    chk(env_flat == exp_env, (op[7:3] == 5'b11100) ? "R3 env" : "R4 env", env_flat, exp_env);
    chk(status_low == {em[6][1:0], em[1][10:0]}, "R5 status", 256'(status_low),
        256'({em[6][1:0], em[1][10:0]}));
  endtask

  task automatic run_packet(input logic [7:0] op, input int gap);
    int n;
    logic ok;
    n = 1 + extra_of(op);
    @(negedge clk); dirty_clr = 1'b1;
    @(negedge clk); dirty_clr = 1'b0;
    @(negedge clk);
    chk(fb_dirty == 1'b0, "R8 clear", 256'(fb_dirty), 256'(0));
    dcnt = 0; xcnt = 0;
    for (int k = 0; k < n; k++) begin
      send_word(pw(op, k));
      if (gap > 0 && k == 1) repeat (gap) @(negedge clk);
    end
    if (op == 8'hA0 || op == 8'hC0) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R7 ready on request", 256'(in_ready), 256'(0));
      @(negedge clk);
      chk(in_ready == 1'b0, "R7 ready while busy", 256'(in_ready), 256'(0));
      chk(dcnt == 0, "R6 no draw", 256'(dcnt), 256'(0));
      chk(xcnt == 1 && xp == pw(op, 1) && xs == pw(op, 2) && xr == (op == 8'hC0),
          "R6 request", {xp, xs, 31'(xcnt), xr}, {pw(op, 1), pw(op, 2), 31'(1), op == 8'hC0});
    end else begin
      @(negedge clk); @(negedge clk);
      chk(dcnt == n, (gap > 0) ? "R9 count" : "R1 length", 256'(dcnt), 256'(n));
      ok = 1'b1;
      for (int k = 0; k < n && k < 16; k++)
        if (dlog[k] != pw(op, k) || dsop[k] != (k == 0) || deop[k] != (k == n - 1)) ok = 1'b0;
      chk(ok, (gap > 0) ? "R9 order" : "R2 words", 256'(op), 256'(n));
    end
    model_pkt(op, n);
    check_state(op);
    chk(fb_dirty == (op >= 8'h02 && op < 8'hC0), "R8 dirty", 256'(fb_dirty),
        256'(op >= 8'h02 && op < 8'hC0));
    repeat (7) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) em[i] = {8'hE0 + 8'(i), 24'h0};
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(draw_valid == 0 && xfer_valid == 0 && fb_dirty == 0, "R10 outputs",
        {draw_valid, xfer_valid, fb_dirty}, 0);
    chk(in_ready == 1'b1, "R10 ready", 256'(in_ready), 256'(1));
    chk(status_low == 13'h0, "R10 status", 256'(status_low), 0);
    for (int i = 0; i < 8; i++)
      chk(env_flat[i*32 +: 32] == {8'hE0 + 8'(i), 24'h0}, "R10 env",
          256'(env_flat[i*32 +: 32]), 256'({8'hE0 + 8'(i), 24'h0}));
    // full opcode sweep
    for (int op = 0; op < 256; op++) run_packet(8'(op), 0);
    // partial packets held across idle gaps
    run_packet(8'h2C, 6);
    run_packet(8'h3D, 3);
    run_packet(8'hE6, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule